// File: doc/BRIEF.md
# Two-Phase Programmable Tone Generator

This block drives a speaker line with a square-ish tone whose low time and high time are programmed independently. Software writes an 8-bit seed for each half of the period and a control byte that picks one of two count rates and starts or stops the tone. Each half is timed by its own up-counter. The counter is loaded with the seed when its half begins and advances on each rate tick. When it rolls past all ones, a single flip-flop that drives the tone output toggles, and the other counter takes over.

Both count rates come from dividing the system clock, so they act as clock enables and no second clock domain exists. With the default dividers on a 125 MHz clock the rates are about 313 kHz and 78 kHz. This gives tones in roughly the 200 Hz to 1000 Hz band and lets software set any duty cycle. The other control bits (pump, valve, backlight, front-end clock, flash enable, converter reset) are only held in the control register and shown on an output for the neighbouring logic.

Top module: `tone_gen`

## Requirements
- R1: After reset, tone_out is 0 and all eight control bits read 0.
- R2: A one-cycle write with wr_en high stores wr_data in the high-time seed at offset 4, in the low-time seed at offset 6, and in the control byte at offset 8. A write to any other offset changes neither the stored values nor the tone.
- R3: Control bit 2 is the rate select and bit 3 is the run bit. Bits 0, 1 and 4 to 7 are stored and appear on ctrl_q, and they have no effect on tone_out.
- R4: When the run bit is set, tone_out stays 0 for (256 - low seed) rate ticks and then goes to 1.
- R5: tone_out stays 1 for (256 - high seed) rate ticks and then returns to 0. The two phases then alternate for as long as the run bit stays 1.
- R6: With rate select 0, one tick occurs every FAST_DIV clocks. With rate select 1, one tick occurs every SLOW_DIV clocks. Ticks occur only while the run bit is 1.
- R7: Clearing the run bit drives tone_out to 0 by the second clock edge after the write, and it stays 0. Setting the run bit again starts a complete low phase.
- R8: A seed of 255 gives a phase of one tick. A seed of 0 gives a phase of 256 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | ADDR_W | Register offset from the block base |
| wr_data | input | DATA_W | Write data |
| ctrl_q | output | 8 | Stored control byte |
| tone_out | output | 1 | Speaker tone |

## Verification
The bench measures each phase in clock cycles, because an off-by-one in the reload would make every phase one tick too long or too short. The seeds 255 and 0 are included: a counter that stops one value early, or that wraps instead of reloading, would make these phases 0 ticks or 257 ticks long. The bench stops the tone in the middle of a high phase and then restarts it. A design that does not reset the phase state would leave the line high, or would resume part-way through a phase. Writes to unmapped offsets and to the unrelated control bits are also tried, since a loose address decode would corrupt the seeds.

// File: rtl/tone_pkg.sv
package tone_pkg;
   localparam int unsigned OFS_HIGH = 4;
   localparam int unsigned OFS_LOW  = 6;
   localparam int unsigned OFS_CTRL = 8;
   localparam int BIT_RATE = 2;
   localparam int BIT_RUN  = 3;
   localparam int CTRL_W   = 8;
   typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/tone_reg_file.sv
module tone_reg_file #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [DATA_W-1:0]         high_q,
   output logic [DATA_W-1:0]         low_q,
   output logic [tone_pkg::CTRL_W-1:0] ctrl_q
);
   import tone_pkg::*;
   logic sel_high, sel_low, sel_ctrl;
   assign sel_high = wr_en && (wr_addr == ADDR_W'(OFS_HIGH));
   assign sel_low  = wr_en && (wr_addr == ADDR_W'(OFS_LOW));
   assign sel_ctrl = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         high_q <= '0;
         low_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (sel_high) high_q <= wr_data;
         if (sel_low)  low_q  <= wr_data;
         if (sel_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
      end
   end
endmodule

// File: rtl/tone_tick_gen.sv
module tone_tick_gen #(
   parameter int FAST_DIV = 400,
   parameter int SLOW_DIV = 1600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic slow,
   output logic tick
);
   localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
   localparam int CW   = $clog2(MAXD);

   logic [CW-1:0] cnt, lim;

   if (FAST_DIV == SLOW_DIV) begin : g_single
      assign lim = CW'(FAST_DIV - 1);
   end else begin : g_dual
      assign lim = slow ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
   end

   assign tick = run && (cnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || cnt >= lim) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tone_phase_ctr.sv
module tone_phase_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         step,
   output logic         ovf
);
   logic [W-1:0] cnt;
   assign ovf = step && (cnt == '1);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= seed;
      else if (step) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int FAST_DIV = 400,
   parameter int SLOW_DIV = 1600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [7:0]        ctrl_q,
   output logic              tone_out
);
   import tone_pkg::*;

   if (ADDR_W < 4)   begin : g_bad_addr  $error("ADDR_W must reach offset 8"); end
   if (DATA_W < 8)   begin : g_bad_data  $error("DATA_W must hold the control byte"); end
   if (FAST_DIV < 2) begin : g_bad_fast  $error("FAST_DIV must be at least 2"); end
   if (SLOW_DIV < 2) begin : g_bad_slow  $error("SLOW_DIV must be at least 2"); end

   logic [DATA_W-1:0] high_q, low_q;
   logic              run, tick;
   logic [1:0]        ovf;
   logic [1:0][DATA_W-1:0] seeds;
   phase_e            phase_q;

   tone_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .high_q(high_q), .low_q(low_q), .ctrl_q(ctrl_q));

   assign run = ctrl_q[BIT_RUN];

   tone_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .slow(ctrl_q[BIT_RATE]), .tick(tick));

   assign seeds[0] = low_q;
   assign seeds[1] = high_q;

   for (genvar i = 0; i < 2; i++) begin : g_half
      localparam phase_e OWN_PH = (i == 0) ? PH_LOW : PH_HIGH;
      tone_phase_ctr #(.W(DATA_W)) u_ctr (
         .clk(clk), .rst_n(rst_n),
         .load(!run || ovf[1-i]),
         .seed(seeds[i]),
         .step(tick && (phase_q == OWN_PH)),
         .ovf(ovf[i]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) phase_q <= PH_LOW;
      else if (ovf[0])    phase_q <= PH_HIGH;
      else if (ovf[1])    phase_q <= PH_LOW;
   end

   assign tone_out = (phase_q == PH_HIGH);
endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [7:0]        ctrl_q,
   input logic              tone_out,
   input logic              tick
);
   import tone_pkg::*;

   // R7
   stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctrl_q[BIT_RUN]) |-> !tone_out);

   // R5
   toggle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tone_out) |-> ($past(tick) || !$past(ctrl_q[BIT_RUN])));

   // R2
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != ADDR_W'(OFS_CTRL)) |=> $stable(ctrl_q));

   // R3
   ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(OFS_CTRL)) |=> ctrl_q == $past(wr_data[7:0]));

   // R6
   tick_sparse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R6
   tick_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> ctrl_q[BIT_RUN]);
endmodule

bind tone_gen tone_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .ctrl_q(ctrl_q), .tone_out(tone_out), .tick(tick));

// File: tb/tb_tone_gen.sv
module tb_tone_gen;
   import tone_pkg::*;
   localparam int FD = 4;
   localparam int SD = 16;
   localparam int NV = 7;
   // {low seed, high seed, rate select}
   localparam logic [16:0] VEC [NV] = '{
      {8'd250, 8'd252, 1'b0},
      {8'd253, 8'd240, 1'b0},
      {8'd255, 8'd255, 1'b0},
      {8'd254, 8'd250, 1'b1},
      {8'd0,   8'd255, 1'b0},
      {8'd255, 8'd0,   1'b0},
      {8'd200, 8'd230, 1'b0}};

   logic clk = 0, rst_n = 0, wr_en = 0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] ctrl_q;
   logic tone_out;
   int n_chk = 0, n_fail = 0;

   tone_gen #(.ADDR_W(4), .DATA_W(8), .FAST_DIV(FD), .SLOW_DIV(SD)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ctrl_q(ctrl_q), .tone_out(tone_out));

   always #4 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a[3:0]; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic span(input logic lvl, output int n);
      n = 0;
      while (tone_out === lvl && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n, hi_seen;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 tone after reset", tone_out, 0);
      chk("R1 ctrl after reset", ctrl_q, 0);

      for (int i = 0; i < NV; i++) begin
         logic [7:0] lo, hi;
         logic sl;
         int d;
         lo = VEC[i][16:9]; hi = VEC[i][8:1]; sl = VEC[i][0];
         d = sl ? SD : FD;
         wr(OFS_LOW, lo);
         wr(OFS_HIGH, hi);
         wr(OFS_CTRL, {4'b0000, 1'b1, sl, 2'b00});
         span(1'b0, n);
         chk((lo == 0 || lo == 255) ? "R8 first low" : (sl ? "R6 first low" : "R4 first low"),
             n, d * (256 - lo));
         span(1'b1, n);
         chk((hi == 0 || hi == 255) ? "R8 high" : (sl ? "R6 high" : "R5 high"),
             n, d * (256 - hi));
         span(1'b0, n);
         chk("R4 repeated low", n, d * (256 - lo));
         span(1'b1, n);
         chk("R5 repeated high", n, d * (256 - hi));
         wr(OFS_CTRL, 8'h00);
         @(negedge clk);
      end

      // other control bits only stored
      wr(OFS_CTRL, 8'hF3);
      chk("R3 ctrl readback", ctrl_q, 8'hF3);
      hi_seen = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (tone_out) hi_seen++;
      end
      chk("R3 no tone from other bits", hi_seen, 0);
      wr(OFS_CTRL, 8'h00);

      // unmapped offsets ignored
      wr(OFS_LOW, 8'd250);
      wr(OFS_HIGH, 8'd251);
      wr(5, 8'h00);
      wr(7, 8'h00);
      wr(9, 8'hFF);
      chk("R2 ctrl untouched", ctrl_q, 0);
      wr(OFS_CTRL, 8'h08);
      span(1'b0, n);
      chk("R2 low seed kept", n, FD * 6);
      span(1'b1, n);
      chk("R2 high seed kept", n, FD * 5);

      // stop in mid high phase, then restart
      span(1'b0, n);
      repeat (3) @(negedge clk);
      chk("R7 high before stop", tone_out, 1);
      wr(OFS_CTRL, 8'h00);
      @(negedge clk);
      chk("R7 low after stop", tone_out, 0);
      hi_seen = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (tone_out) hi_seen++;
      end
      chk("R7 stays low", hi_seen, 0);
      wr(OFS_CTRL, 8'h08);
      span(1'b0, n);
      chk("R7 restart full low", n, FD * 6);
      wr(OFS_CTRL, 8'h00);
      @(negedge clk);

      finish_run();
   end
endmodule